// File: doc/BRIEF.md
# Multiprocessor UART Address Filter

This block filters received frames on a shared 9-bit serial bus where several nodes listen on one line. A receiver core hands over each finished frame as a one-cycle strobe. The strobe carries eight data bits and the extra ninth bit, which is the one sent after the data and before the stop bits. A frame with the ninth bit set is an address frame. A frame with it clear is a data frame. The block compares each address frame with a programmable node address. A small state machine then records whether the data that follows belongs to this node.

Only the bytes that pass the filter reach the host side. Each forwarded byte appears one clock after its frame, with two flags. One flag copies the frame's ninth bit. The other marks the first data byte after a matching address. A two-bit filter select chooses how the filter behaves. In pass-all mode, software makes the decision. In match mode, hardware makes the decision. In match-and-show-address mode, hardware decides and the host still sees every address byte. A separate enable turns multiprocessor handling off. When it is off, the block forwards everything unfiltered.

The selection machine has three states:
- `ST_UNSEL`: not addressed.
- `ST_ARMED`: matched, waiting for the first data byte.
- `ST_ACTIVE`: matched, first data byte already delivered.

It has these transitions:
- hit: any state goes to `ST_ARMED` on a matching address frame.
- miss: any state goes to `ST_UNSEL` on a non-matching address frame.
- first: `ST_ARMED` goes to `ST_ACTIVE` on a data frame.
- clear: any state goes to `ST_UNSEL` whenever the enable is low.

Top module: `mpf_top`

## Requirements
- R1: After reset, `out_valid` is 0 and the selection state is unselected. A data frame received before any address frame is dropped when `filt_mode` is 01.
- R2: Every forwarded frame appears as a one-cycle `out_valid` pulse in the clock cycle after its `frm_valid` strobe. `out_byte` equals `frm_byte` in that pulse.
- R3: While `mp_enable` is 0, every frame is forwarded with `out_is_addr` equal to `frm_mpbit` and `out_first` equal to 0. The selection state is cleared, so after re-enabling with `filt_mode` 01, a data frame is dropped.
- R4: An address frame (`frm_mpbit`=1) whose byte equals `node_addr` selects the node, whatever the previous state.
- R5: An address frame whose byte differs from `node_addr` deselects the node.
- R6: With `filt_mode` 01, address frames are never forwarded. Data frames (`frm_mpbit`=0) are forwarded only while selected.
- R7: With `filt_mode` 10, every address frame is forwarded with `out_is_addr`=1. Data frames are forwarded only while selected.
- R8: With `filt_mode` 00 and `mp_enable` 1, every frame is forwarded, and the selection state and flags are still maintained.
- R9: `out_first` is 1 only on the first data byte after a matching address frame. A repeated match arms it again.
- R10: `filt_mode` 11 behaves exactly as `filt_mode` 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid | input | 1 | One-cycle strobe: a received frame is present |
| frm_byte | input | 8 | Eight data bits of the frame |
| frm_mpbit | input | 1 | Ninth bit of the frame (1 = address frame) |
| node_addr | input | 8 | This node's address for comparison |
| mp_enable | input | 1 | Multiprocessor handling enable |
| filt_mode | input | 2 | 00 pass all, 01 match, 10 match and show addresses, 11 as 01 |
| out_valid | output | 1 | One-cycle strobe: forwarded byte present |
| out_byte | output | 8 | Forwarded byte |
| out_is_addr | output | 1 | Ninth bit of the forwarded frame |
| out_first | output | 1 | First data byte after a matching address |

## Verification
The hardest situation to reach is the transition from `ST_ARMED` to `ST_ACTIVE` after a repeated match, while the enable or the mode changes between frames. The ports cannot show the first flag unless a data frame follows right after the address. The stimulus therefore sends sequences that match twice in a row, move from match to miss, and switch modes while a node is selected. It then disables and re-enables the block right after arming, which shows that the clear transition wins. A scoreboard model predicts each frame's output, or its absence, one cycle after every strobe.

// File: rtl/mpf_pkg.sv
package mpf_pkg;
    typedef enum logic [1:0] {
        ST_UNSEL  = 2'd0,
        ST_ARMED  = 2'd1,
        ST_ACTIVE = 2'd2
    } sel_st_e;

    typedef enum logic [1:0] {
        FM_PASS       = 2'b00,
        FM_MATCH      = 2'b01,
        FM_MATCH_ADDR = 2'b10,
        FM_MATCH_ALT  = 2'b11
    } filt_mode_e;
endpackage

// File: rtl/mpf_addr_cmp.sv
module mpf_addr_cmp #(
    parameter int W = 8
) (
    input  logic         frm_mpbit,
    input  logic [W-1:0] frm_byte,
    input  logic [W-1:0] node_addr,
    output logic         is_addr,
    output logic         addr_hit
);
    always_comb begin
        is_addr  = frm_mpbit;
        addr_hit = frm_mpbit && (frm_byte == node_addr);
    end
endmodule

// File: rtl/mpf_sel_fsm.sv
module mpf_sel_fsm
    import mpf_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    frm_valid,
    input  logic    mp_enable,
    input  logic    is_addr,
    input  logic    addr_hit,
    output sel_st_e state
);
    sel_st_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_UNSEL;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!mp_enable) begin
            state_nx = ST_UNSEL;
        end else if (frm_valid && is_addr) begin
            state_nx = addr_hit ? ST_ARMED : ST_UNSEL;
        end else if (frm_valid) begin
            unique case (state)
                ST_UNSEL:  state_nx = ST_UNSEL;
                ST_ARMED:  state_nx = ST_ACTIVE;
                ST_ACTIVE: state_nx = ST_ACTIVE;
                default:   state_nx = ST_UNSEL;
            endcase
        end
    end

    // R3
    clear_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mp_enable |=> state == ST_UNSEL);

    // R5
    miss_deselects_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && mp_enable && is_addr && !addr_hit |=> state == ST_UNSEL);

    // R4
    hit_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && mp_enable && addr_hit |=> state == ST_ARMED);
endmodule

// File: rtl/mpf_fwd.sv
module mpf_fwd
    import mpf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frm_valid,
    input  logic [W-1:0] frm_byte,
    input  logic         frm_mpbit,
    input  logic         mp_enable,
    input  logic [1:0]   filt_mode,
    input  sel_st_e      state,
    output logic         out_valid,
    output logic [W-1:0] out_byte,
    output logic         out_is_addr,
    output logic         out_first
);
    filt_mode_e mode;
    logic       take;
    logic       first;

    always_comb begin
        mode  = filt_mode_e'(filt_mode);
        take  = 1'b0;
        first = 1'b0;
        if (!mp_enable) begin
            take = 1'b1;
        end else if (frm_mpbit) begin
            take = (mode == FM_PASS) || (mode == FM_MATCH_ADDR);
        end else begin
            take  = (mode == FM_PASS) || (state != ST_UNSEL);
            first = (state == ST_ARMED);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_byte    <= '0;
            out_is_addr <= 1'b0;
            out_first   <= 1'b0;
        end else begin
            out_valid <= frm_valid && take;
            if (frm_valid && take) begin
                out_byte    <= frm_byte;
                out_is_addr <= frm_mpbit;
                out_first   <= first;
            end
        end
    end

    // R2
    pulse_follows_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(frm_valid));

    // R9
    first_only_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_first |-> !out_is_addr);

    // R3
    bypass_forwards_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && !mp_enable |=> out_valid && !out_first);
endmodule

// File: rtl/mpf_top.sv
module mpf_top
    import mpf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic [DATA_W-1:0] frm_byte,
    input  logic              frm_mpbit,
    input  logic [DATA_W-1:0] node_addr,
    input  logic              mp_enable,
    input  logic [1:0]        filt_mode,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_byte,
    output logic              out_is_addr,
    output logic              out_first
);
    logic    is_addr;
    logic    addr_hit;
    sel_st_e state;

    mpf_addr_cmp #(.W(DATA_W)) u_cmp (
        .frm_mpbit (frm_mpbit),
        .frm_byte  (frm_byte),
        .node_addr (node_addr),
        .is_addr   (is_addr),
        .addr_hit  (addr_hit)
    );

    mpf_sel_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_valid (frm_valid),
        .mp_enable (mp_enable),
        .is_addr   (is_addr),
        .addr_hit  (addr_hit),
        .state     (state)
    );

    mpf_fwd #(.W(DATA_W)) u_fwd (
        .clk         (clk),
        .rst_n       (rst_n),
        .frm_valid   (frm_valid),
        .frm_byte    (frm_byte),
        .frm_mpbit   (frm_mpbit),
        .mp_enable   (mp_enable),
        .filt_mode   (filt_mode),
        .state       (state),
        .out_valid   (out_valid),
        .out_byte    (out_byte),
        .out_is_addr (out_is_addr),
        .out_first   (out_first)
    );

    // R6
    unsel_data_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && mp_enable && !frm_mpbit && state == ST_UNSEL
        && filt_mode != FM_PASS |=> !out_valid);

    // R8
    pass_all_forwards_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && mp_enable && filt_mode == FM_PASS |=> out_valid);
endmodule

// File: tb/mpf_top_tb.sv
`timescale 1ns/1ps
module mpf_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_valid = 1'b0;
    logic [7:0] frm_byte = '0;
    logic       frm_mpbit = 1'b0;
    logic [7:0] node_addr = 8'h5A;
    logic       mp_enable = 1'b0;
    logic [1:0] filt_mode = 2'b00;
    logic       out_valid;
    logic [7:0] out_byte;
    logic       out_is_addr;
    logic       out_first;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int sel    = 0;   // model: 0 unselected, 1 armed, 2 active
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] b;
        logic       v;
        logic       a;
        logic       f;
        int         due;
        string      req;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mpf_top u_dut (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_byte(frm_byte),
        .frm_mpbit(frm_mpbit), .node_addr(node_addr), .mp_enable(mp_enable),
        .filt_mode(filt_mode), .out_valid(out_valid), .out_byte(out_byte),
        .out_is_addr(out_is_addr), .out_first(out_first)
    );

    task automatic send(input logic [7:0] b, input logic mp, input string req);
        exp_t e;
        @(negedge clk);
        e.b = b; e.a = mp; e.f = 1'b0; e.v = 1'b0; e.req = req; e.due = cyc + 1;
        if (!mp_enable) begin
            e.v = 1'b1; sel = 0;
        end else if (mp) begin
            sel = (b == node_addr) ? 1 : 0;
            e.v = (filt_mode == 2'b00) || (filt_mode == 2'b10);
        end else begin
            e.v = (filt_mode == 2'b00) || (sel != 0);
            e.f = (sel == 1);
            if (sel == 1) sel = 2;
        end
        q.push_back(e);
        frm_valid = 1'b1; frm_byte = b; frm_mpbit = mp;
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    task automatic set_cfg(input logic en, input logic [1:0] m);
        @(negedge clk);
        mp_enable = en; filt_mode = m;
        if (!en) sel = 0;
        @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (out_valid !== e.v ||
                    (e.v && (out_byte !== e.b || out_is_addr !== e.a || out_first !== e.f))) begin
                    fails++;
                    $display("FAIL %s: got v=%b b=%h a=%b f=%b exp v=%b b=%h a=%b f=%b",
                             e.req, out_valid, out_byte, out_is_addr, out_first,
                             e.v, e.b, e.a, e.f);
                end
            end else if (out_valid) begin
                checks++; fails++;
                $display("FAIL R2: unexpected pulse got b=%h exp no output", out_byte);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: got hang exp completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: reset out_valid got %b exp 0", out_valid);
        end
        rst_n = 1'b1;
        set_cfg(1'b1, 2'b01);
        send(8'h11, 1'b0, "R1");
        send(8'h33, 1'b1, "R6");
        send(8'h22, 1'b0, "R6");
        send(8'h5A, 1'b1, "R4");
        send(8'h44, 1'b0, "R9");
        send(8'h45, 1'b0, "R6");
        send(8'h5A, 1'b1, "R4");
        send(8'h46, 1'b0, "R9");
        send(8'h77, 1'b1, "R5");
        send(8'h47, 1'b0, "R5");
        set_cfg(1'b1, 2'b10);
        send(8'h12, 1'b1, "R7");
        send(8'h48, 1'b0, "R7");
        send(8'h5A, 1'b1, "R7");
        send(8'h49, 1'b0, "R9");
        send(8'h4A, 1'b0, "R7");
        set_cfg(1'b1, 2'b00);
        send(8'h99, 1'b1, "R8");
        send(8'h10, 1'b0, "R8");
        send(8'h5A, 1'b1, "R8");
        send(8'h13, 1'b0, "R8");
        set_cfg(1'b1, 2'b11);
        send(8'h5A, 1'b1, "R10");
        send(8'h14, 1'b0, "R10");
        send(8'h01, 1'b1, "R10");
        send(8'h15, 1'b0, "R10");
        set_cfg(1'b1, 2'b01);
        send(8'h5A, 1'b1, "R4");
        set_cfg(1'b0, 2'b01);
        send(8'h20, 1'b0, "R3");
        send(8'h5A, 1'b1, "R3");
        set_cfg(1'b1, 2'b01);
        send(8'h21, 1'b0, "R3");
        node_addr = 8'hC3;
        send(8'hC3, 1'b1, "R4");
        send(8'h00, 1'b0, "R2");
        send(8'hFF, 1'b0, "R2");
        repeat (3) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R2: pending items got %0d exp 0", q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule